// File: doc/BRIEF.md
# Bus Timeout Error Status Register

This block keeps a 32-bit error status word for the processor-to-memory interconnect. When an access times out, it records the first such event and the access context: whether the reference was virtual, and the access mode ORed into a two-bit field. It also tells the rest of the processor what to do next. A timed-out read raises a machine-check request. A timed-out write raises a memory-error interrupt request instead.

Once an error is captured, the capture flag stays set until the processor signals that the machine check has been delivered. Any timeout that arrives while the flag is set only sets a lost-error bit, and the recorded context is left as it was. The lost-error bit and the context fields stay set until reset.

Top module: `bus_tmo_status`

## Requirements
- R1: After a synchronous reset, `status_o` reads 0x0010_0000 (only bit 20, error enable, set), and both `mchk_req_o` and `memerr_irq_o` are low.
- R2: A timeout while bit 3 (capture) is clear sets bit 3 on the next clock edge.
- R3: On a captured timeout with `virt_i` high, bit 18 is set and `mode_i` is ORed into bits 17:16. On a captured timeout with `virt_i` low, bits 18:16 are left unchanged.
- R4: A timeout while bit 3 is already set sets bit 1 (lost error) and changes no other bit of `status_o`.
- R5: A timeout with `wr_i` low produces a one-cycle pulse on `mchk_req_o` in the cycle after the timeout. A timeout with `wr_i` high produces no such pulse.
- R6: A timeout with `wr_i` high sets `memerr_irq_o` on the next edge, and it stays high until `irq_ack_i` clears it on the following edge. When a write timeout and an acknowledge arrive in the same cycle, the request stays set.
- R7: `mchk_done_i` clears bit 3 on the next edge. Bits 1 and 18:16 are kept and are cleared only by reset.
- R8: When a timeout and `mchk_done_i` arrive in the same cycle, the clear is applied first and the timeout is then captured. Bit 3 stays set, bit 1 is not set by that timeout, and the context is recorded as in R3.
- R9: Bits 0, 2, 4, 8 to 11, 19 and 21 to 31 always read 0, and bit 20 always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_i | input | 1 | Bus timeout strobe, one cycle per event |
| wr_i | input | 1 | Direction of the timed-out access: 1 = write, 0 = read |
| virt_i | input | 1 | Timed-out access used a virtual reference |
| mode_i | input | 2 | Current access mode of the processor |
| mchk_done_i | input | 1 | Machine check delivered; re-arms capture |
| irq_ack_i | input | 1 | Acknowledge of the memory-error interrupt request |
| status_o | output | 32 | Error status word |
| mchk_req_o | output | 1 | Bus-error machine-check request pulse (read timeout) |
| memerr_irq_o | output | 1 | Memory-error interrupt request, held until acknowledged (write timeout) |

## Verification
The bench sends a second timeout while the first is still captured. A design that recaptured here would overwrite or add to the mode field instead of only raising the lost-error bit. It also sends a timeout in the same cycle as the machine-check completion. A design with the wrong priority would report a lost error, or leave bit 3 clear and drop the context.

The bench acknowledges the interrupt in the same cycle as a new write timeout. A design that let the acknowledge win would lose that request. It also checks that the lost-error bit and the mode bits survive a completion, which catches a design that clears the whole word when it re-arms.

// File: rtl/bus_tmo_pkg.sv
package bus_tmo_pkg;
  localparam int STAT_W     = 32;
  localparam int MODE_W     = 2;
  localparam int B_CRD      = 0;
  localparam int B_LOST     = 1;
  localparam int B_RDS      = 2;
  localparam int B_CAP      = 3;
  localparam int B_TBHIT    = 4;
  localparam int B_TBPAR_LO = 8;
  localparam int TBPAR_W    = 4;
  localparam int B_MODE_LO  = 16;
  localparam int B_VREF     = 18;
  localparam int B_REFR     = 19;
  localparam int B_ENA      = 20;

  typedef struct packed {
    logic              cap;
    logic              lost;
    logic              vref;
    logic [MODE_W-1:0] mode;
  } tmo_ctx_t;

  localparam logic [STAT_W-1:0] RST_STATUS = STAT_W'(1) << B_ENA;
endpackage

// File: rtl/btmo_capture.sv
module btmo_capture
  import bus_tmo_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tmo_i,
  input  logic          virt_i,
  input  logic [MW-1:0] mode_i,
  input  logic          done_i,
  output logic          cap_o,
  output logic          lost_o,
  output logic          vref_o,
  output logic [MW-1:0] mode_o
);
  logic          cap_q, lost_q, vref_q;
  logic [MW-1:0] mode_q;
  logic          armed_busy;

  // completion is applied before the incoming timeout
  assign armed_busy = cap_q & ~done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= 1'b0;
      lost_q <= 1'b0;
      vref_q <= 1'b0;
      mode_q <= '0;
    end else if (tmo_i) begin
      if (armed_busy) begin
        lost_q <= 1'b1;
      end else begin
        cap_q <= 1'b1;
        if (virt_i) begin
          vref_q <= 1'b1;
          mode_q <= mode_q | mode_i;
        end
      end
    end else if (done_i) begin
      cap_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign lost_o = lost_q;
  assign vref_o = vref_q;
  assign mode_o = mode_q;

  p_first_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (tmo_i && !cap_q) |=> cap_q);
  p_virt_ctx_r3: assert property (@(posedge clk) disable iff (rst)
    (tmo_i && !armed_busy && virt_i) |=> (vref_q && ((mode_q & $past(mode_i)) == $past(mode_i))));
  p_lost_keeps_ctx_r4: assert property (@(posedge clk) disable iff (rst)
    (tmo_i && armed_busy) |=> (lost_q && cap_q && $stable(vref_q) && $stable(mode_q)));
  p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (done_i && !tmo_i) |=> !cap_q);
  p_lost_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    lost_q |=> lost_q);
  p_vref_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    vref_q |=> vref_q);
  p_same_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    (tmo_i && done_i) |=> (cap_q && $stable(lost_q)));
endmodule

// File: rtl/btmo_outcome.sv
module btmo_outcome (
  input  logic clk,
  input  logic rst,
  input  logic tmo_i,
  input  logic wr_i,
  input  logic ack_i,
  output logic mchk_o,
  output logic irq_o
);
  logic mchk_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mchk_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mchk_q <= tmo_i & ~wr_i;
      if (tmo_i && wr_i)
        irq_q <= 1'b1;
      else if (ack_i)
        irq_q <= 1'b0;
    end
  end

  assign mchk_o = mchk_q;
  assign irq_o  = irq_q;

  p_read_mchk_r5: assert property (@(posedge clk) disable iff (rst)
    (tmo_i && !wr_i) |=> mchk_q);
  p_write_no_mchk_r5: assert property (@(posedge clk) disable iff (rst)
    (tmo_i && wr_i) |=> !mchk_q);
  p_irq_set_r6: assert property (@(posedge clk) disable iff (rst)
    (tmo_i && wr_i) |=> irq_q);
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !ack_i) |=> irq_q);
  p_irq_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !(tmo_i && wr_i)) |=> !irq_q);
endmodule

// File: rtl/btmo_pack.sv
module btmo_pack
  import bus_tmo_pkg::*;
(
  input  tmo_ctx_t          ctx_i,
  output logic [STAT_W-1:0] status_o
);
  always_comb begin
    status_o = '0;
    status_o[B_ENA]  = 1'b1;
    status_o[B_CAP]  = ctx_i.cap;
    status_o[B_LOST] = ctx_i.lost;
    status_o[B_VREF] = ctx_i.vref;
    for (int i = 0; i < MODE_W; i++)
      status_o[B_MODE_LO + i] = ctx_i.mode[i];
  end
endmodule

// File: rtl/bus_tmo_status.sv
module bus_tmo_status
  import bus_tmo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tmo_i,
  input  logic              wr_i,
  input  logic              virt_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              mchk_done_i,
  input  logic              irq_ack_i,
  output logic [STAT_W-1:0] status_o,
  output logic              mchk_req_o,
  output logic              memerr_irq_o
);
  tmo_ctx_t ctx;

  btmo_capture #(.MW(MODE_W)) u_capture (
    .clk    (clk),
    .rst    (rst),
    .tmo_i  (tmo_i),
    .virt_i (virt_i),
    .mode_i (mode_i),
    .done_i (mchk_done_i),
    .cap_o  (ctx.cap),
    .lost_o (ctx.lost),
    .vref_o (ctx.vref),
    .mode_o (ctx.mode)
  );

  btmo_outcome u_outcome (
    .clk    (clk),
    .rst    (rst),
    .tmo_i  (tmo_i),
    .wr_i   (wr_i),
    .ack_i  (irq_ack_i),
    .mchk_o (mchk_req_o),
    .irq_o  (memerr_irq_o)
  );

  btmo_pack u_pack (
    .ctx_i    (ctx),
    .status_o (status_o)
  );

  p_reset_value_r1: assert property (@(posedge clk)
    rst |=> (status_o == RST_STATUS && !mchk_req_o && !memerr_irq_o));
  p_lost_only_r4: assert property (@(posedge clk) disable iff (rst)
    (tmo_i && status_o[B_CAP] && !mchk_done_i) |=>
      ((status_o | (STAT_W'(1) << B_LOST)) == ($past(status_o) | (STAT_W'(1) << B_LOST))));
endmodule

// File: tb/bus_tmo_status_test.sv
module bus_tmo_status_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        tmo_i, wr_i, virt_i, mchk_done_i, irq_ack_i;
  logic [1:0]  mode_i;
  logic [31:0] status_o;
  logic        mchk_req_o, memerr_irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bus_tmo_status uut (
    .clk(clk), .rst(rst), .tmo_i(tmo_i), .wr_i(wr_i), .virt_i(virt_i),
    .mode_i(mode_i), .mchk_done_i(mchk_done_i), .irq_ack_i(irq_ack_i),
    .status_o(status_o), .mchk_req_o(mchk_req_o), .memerr_irq_o(memerr_irq_o)
  );

  typedef struct packed {
    logic        tmo;
    logic        wr;
    logic        virt;
    logic [1:0]  mode;
    logic        done;
    logic        ack;
    logic [31:0] st;
    logic        mchk;
    logic        irq;
  } vec_t;

  localparam int NV = 12;
  // tmo wr virt mode done ack | status mchk irq
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0, 32'h0010_0000,1'b0,1'b0}, // R1 idle
    '{1'b1,1'b0,1'b0,2'd3,1'b0,1'b0, 32'h0010_0008,1'b1,1'b0}, // R2 R5 phys read
    '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0, 32'h0010_0008,1'b0,1'b0}, // R5 pulse ends
    '{1'b1,1'b1,1'b1,2'd2,1'b0,1'b0, 32'h0010_000A,1'b0,1'b1}, // R4 R6 lost
    '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0, 32'h0010_000A,1'b0,1'b1}, // R6 hold
    '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b1, 32'h0010_000A,1'b0,1'b0}, // R6 ack
    '{1'b0,1'b0,1'b0,2'd0,1'b1,1'b0, 32'h0010_0002,1'b0,1'b0}, // R7 re-arm
    '{1'b1,1'b0,1'b1,2'd1,1'b0,1'b0, 32'h0015_000A,1'b1,1'b0}, // R3 virt
    '{1'b1,1'b1,1'b1,2'd2,1'b1,1'b0, 32'h0017_000A,1'b0,1'b1}, // R8 same cycle
    '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b1, 32'h0017_000A,1'b0,1'b1}, // R6 set wins
    '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b1, 32'h0017_000A,1'b0,1'b0}, // R6 ack
    '{1'b0,1'b0,1'b0,2'd0,1'b1,1'b0, 32'h0017_0002,1'b0,1'b0}  // R7 sticky ctx
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic t, input logic w, input logic v, input logic [1:0] m,
                       input logic d, input logic a);
    tmo_i = t; wr_i = w; virt_i = v; mode_i = m; mchk_done_i = d; irq_ack_i = a;
  endtask

  initial begin
    #4_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    drive(0,0,0,2'd0,0,0);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 status", status_o, 32'h0010_0000);
    check("R1 req", {30'd0, mchk_req_o, memerr_irq_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].tmo, TBL[i].wr, TBL[i].virt, TBL[i].mode, TBL[i].done, TBL[i].ack);
      @(negedge clk);
      check($sformatf("vec%0d status R2/R3/R4/R7/R8", i), status_o, TBL[i].st);
      check($sformatf("vec%0d mchk R5", i), {31'd0, mchk_req_o}, {31'd0, TBL[i].mchk});
      check($sformatf("vec%0d irq R6", i), {31'd0, memerr_irq_o}, {31'd0, TBL[i].irq});
      check($sformatf("vec%0d fixed bits R9", i), status_o & 32'hFFF0_FFF5, 32'h0010_0000);
    end

    // R1: reset mid-run clears sticky fields and requests
    drive(1,1,0,2'd0,0,0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(0,0,0,2'd0,0,0);
    check("R1 reset mid-run", status_o, 32'h0010_0000);
    check("R1 irq after reset", {31'd0, memerr_irq_o}, 32'd0);

    // R3: physical capture leaves mode and vref untouched
    drive(1,1,0,2'd3,0,0);
    @(negedge clk);
    drive(0,0,0,2'd0,0,0);
    check("R3 physical capture", status_o, 32'h0010_0008);
    check("R6 write irq", {31'd0, memerr_irq_o}, 32'd1);
    check("R5 write no mchk", {31'd0, mchk_req_o}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule